// File: doc/BRIEF.md
# Bus-to-Stream Port Array

This block is a Wishbone slave that turns single-word memory-mapped accesses into per-port data streams. It offers 2^PORT_BITS ports. Each port has two 16-entry FIFOs. A bus write to the port's address pushes the word into an outbound FIFO. That FIFO drives a compute block through a valid/ready source interface. A bus read from the same address pops one word from an inbound FIFO, which the compute block fills through a valid/ready sink interface. A host can therefore feed and drain a processing block by repeating accesses at one fixed address.

Accesses that cannot complete are not dropped. A write to a full outbound FIFO, or a read from an empty inbound FIFO, is stretched by holding back ACK until space or data appears. If the access has waited a full timeout window of 256 cycles, it ends with ERR instead and has no effect. A separate status word reports the outbound-full and inbound-empty flags of every port, so software can poll before it issues an access.

Top module: `wb_port_array`

## Requirements
- R1: The port index is word-address bits [PORT_BITS+1:2] while bit PORT_BITS+2 is 0. A completed write to port k appears only on source stream k, and source streams k keeps their words in write order.
- R2: A completed read of port k returns the oldest word the sink stream k has delivered, in arrival order.
- R3: An outbound FIFO accepts 16 writes with no stall while its stream is not drained, and all 16 words then leave in order.
- R4: A write to a port whose outbound FIFO is full gets no ACK. If the FIFO is still full after 256 cycles, ERR is raised in cycle 256 counted from the first edge that sees the request, and nothing is pushed.
- R5: A read from a port whose inbound FIFO is empty ends with ERR after the same 256-cycle window and pops nothing.
- R6: If space or data appears while an access is waiting, the access completes with ACK before the window ends.
- R7: snk_ready_o[k] is low exactly when inbound FIFO k holds 16 words. A word offered while it is low is not taken.
- R8: src_valid_o[k] is high when outbound FIFO k is non-empty, and src_data_o slice k shows the head word. Both stay unchanged while src_ready_i[k] is low.
- R9: A read at word address with bit PORT_BITS+2 set returns the status word. Bits [NP-1:0] are the outbound-full flags and bits [2NP-1:NP] are the inbound-empty flags, with all other bits zero. A write there gets ACK and changes nothing.
- R10: After reset, ACK and ERR are low, every src_valid_o is low, every snk_ready_o is high, and the status word shows all inbound FIFOs empty.
- R11: An access that can proceed gets ACK in the cycle after the first edge that sees the request. ACK and ERR are never high together, and each is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 3 | Word address bits [4:2] |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Access completed |
| wb_err_o | output | 1 | Access timed out |
| src_valid_o | output | 4 | Per-port outbound word valid |
| src_data_o | output | 128 | Per-port outbound head word, port k in bits [32k+31:32k] |
| src_ready_i | input | 4 | Per-port outbound consumer ready |
| snk_valid_i | input | 4 | Per-port inbound word valid |
| snk_data_i | input | 128 | Per-port inbound word, port k in bits [32k+31:32k] |
| snk_ready_o | output | 4 | Per-port inbound FIFO can accept |

## Verification
A corrupted FIFO pointer or count shows up within one access at the ports. It appears as a wrong head word on a source stream, a wrong word returned by a read, a ready or valid flag that disagrees with the number of words moved, or a status word that differs from that count. A wrong port decode sends a word to a neighbour's stream on the very next cycle. A faulty wait counter moves ERR away from cycle 256 of a blocked access, or lets a blocked access push or pop. These faults are seen by counting cycles from the request and by draining the affected FIFO afterwards.

// File: rtl/wbpa_pkg.sv
package wbpa_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_DONE = 1'b1
  } acc_state_e;
endpackage

// File: rtl/wbpa_fifo.sv
module wbpa_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end
endmodule

// File: rtl/wbpa_port.sv
module wbpa_port #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_push,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_pop,
  output logic [DW-1:0] bus_rhead,
  output logic          out_full,
  output logic          in_empty,
  output logic          src_valid,
  output logic [DW-1:0] src_data,
  input  logic          src_ready,
  input  logic          snk_valid,
  input  logic [DW-1:0] snk_data,
  output logic          snk_ready
);
  logic out_empty, in_full;

  wbpa_fifo #(.DW(DW), .DEPTH(DEPTH)) u_out (
    .clk(clk), .rst_n(rst_n),
    .push(bus_push), .push_data(bus_wdata),
    .pop(src_ready), .head(src_data),
    .full(out_full), .empty(out_empty)
  );

  wbpa_fifo #(.DW(DW), .DEPTH(DEPTH)) u_in (
    .clk(clk), .rst_n(rst_n),
    .push(snk_valid), .push_data(snk_data),
    .pop(bus_pop), .head(bus_rhead),
    .full(in_full), .empty(in_empty)
  );

  assign src_valid = !out_empty;
  assign snk_ready = !in_full;
endmodule

// File: rtl/wbpa_ctrl.sv
module wbpa_ctrl
  import wbpa_pkg::*;
#(
  parameter int PORT_BITS = 2,
  parameter int DW        = 32,
  parameter int TIMEOUT   = 256,
  localparam int NP       = 1 << PORT_BITS,
  localparam int ADR_W    = PORT_BITS + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc,
  input  logic             stb,
  input  logic             we,
  input  logic [ADR_W-1:2] adr,
  input  logic [NP-1:0]    out_full,
  input  logic [NP-1:0]    in_empty,
  input  logic [NP*DW-1:0] rd_heads,
  output logic [NP-1:0]    wr_push,
  output logic [NP-1:0]    rd_pop,
  output logic [DW-1:0]    dat_o,
  output logic             ack_o,
  output logic             err_o
);
  localparam int WCW = $clog2(TIMEOUT) + 1;

  acc_state_e            st_q, st_d;
  logic [WCW-1:0]        wait_q, wait_d;
  logic                  ack_q, ack_d, err_q, err_d;
  logic [DW-1:0]         dat_q, dat_d;
  logic                  dat_en;
  logic                  req, is_stat, blocked, go, expire;
  logic [PORT_BITS-1:0]  sel;
  logic [DW-1:0]         stat_word, head_sel;

  assign req     = cyc && stb && (st_q == ST_IDLE);
  assign is_stat = adr[PORT_BITS+2];
  assign sel     = adr[PORT_BITS+1:2];
  assign blocked = !is_stat && (we ? out_full[sel] : in_empty[sel]);
  assign go      = req && !blocked;
  assign expire  = req && blocked && (wait_q == WCW'(TIMEOUT - 1));
  assign head_sel = rd_heads[sel*DW +: DW];

  always_comb begin
    stat_word = '0;
    stat_word[NP-1:0]    = out_full;
    stat_word[2*NP-1:NP] = in_empty;
  end

  generate
    for (genvar p = 0; p < NP; p++) begin : g_strobe
      assign wr_push[p] = go && we  && !is_stat && (sel == PORT_BITS'(p));
      assign rd_pop[p]  = go && !we && !is_stat && (sel == PORT_BITS'(p));
    end
  endgenerate

  always_comb begin
    st_d   = st_q;
    wait_d = '0;
    ack_d  = 1'b0;
    err_d  = 1'b0;
    dat_en = 1'b0;
    dat_d  = is_stat ? stat_word : head_sel;
    case (st_q)
      ST_IDLE: begin
        if (go) begin
          st_d   = ST_DONE;
          ack_d  = 1'b1;
          dat_en = !we;
        end else if (expire) begin
          st_d  = ST_DONE;
          err_d = 1'b1;
        end else if (req) begin
          wait_d = wait_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wait_q <= '0;
      ack_q  <= 1'b0;
      err_q  <= 1'b0;
      dat_q  <= '0;
    end else begin
      st_q   <= st_d;
      wait_q <= wait_d;
      ack_q  <= ack_d;
      err_q  <= err_d;
      if (dat_en) dat_q <= dat_d;
    end
  end

  assign dat_o = dat_q;
  assign ack_o = ack_q;
  assign err_o = err_q;
endmodule

// File: rtl/wb_port_array.sv
module wb_port_array #(
  parameter int PORT_BITS = 2,
  parameter int DW        = 32,
  parameter int DEPTH     = 16,
  parameter int TIMEOUT   = 256,
  localparam int NP       = 1 << PORT_BITS,
  localparam int ADR_W    = PORT_BITS + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_cyc_i,
  input  logic             wb_stb_i,
  input  logic             wb_we_i,
  input  logic [ADR_W-1:2] wb_adr_i,
  input  logic [DW-1:0]    wb_dat_i,
  output logic [DW-1:0]    wb_dat_o,
  output logic             wb_ack_o,
  output logic             wb_err_o,
  output logic [NP-1:0]    src_valid_o,
  output logic [NP*DW-1:0] src_data_o,
  input  logic [NP-1:0]    src_ready_i,
  input  logic [NP-1:0]    snk_valid_i,
  input  logic [NP*DW-1:0] snk_data_i,
  output logic [NP-1:0]    snk_ready_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic [NP-1:0]    wr_push, rd_pop, out_full, in_empty;
  logic [NP*DW-1:0] rd_heads;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  wbpa_ctrl #(.PORT_BITS(PORT_BITS), .DW(DW), .TIMEOUT(TIMEOUT)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .cyc(wb_cyc_i), .stb(wb_stb_i), .we(wb_we_i), .adr(wb_adr_i),
    .out_full(out_full), .in_empty(in_empty), .rd_heads(rd_heads),
    .wr_push(wr_push), .rd_pop(rd_pop),
    .dat_o(wb_dat_o), .ack_o(wb_ack_o), .err_o(wb_err_o)
  );

  generate
    for (genvar p = 0; p < NP; p++) begin : g_port
      wbpa_port #(.DW(DW), .DEPTH(DEPTH)) u_port (
        .clk(clk), .rst_n(rst_sync_n),
        .bus_push(wr_push[p]), .bus_wdata(wb_dat_i),
        .bus_pop(rd_pop[p]), .bus_rhead(rd_heads[p*DW +: DW]),
        .out_full(out_full[p]), .in_empty(in_empty[p]),
        .src_valid(src_valid_o[p]), .src_data(src_data_o[p*DW +: DW]),
        .src_ready(src_ready_i[p]),
        .snk_valid(snk_valid_i[p]), .snk_data(snk_data_i[p*DW +: DW]),
        .snk_ready(snk_ready_o[p])
      );
    end
  endgenerate
endmodule

// File: rtl/wbpa_checker.sv
module wbpa_checker #(
  parameter int NP = 4,
  parameter int DW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc,
  input logic             stb,
  input logic             ack,
  input logic             err,
  input logic [NP-1:0]    src_valid,
  input logic [NP-1:0]    src_ready,
  input logic [NP*DW-1:0] src_data,
  input logic [NP-1:0]    push_vec,
  input logic [NP-1:0]    out_full
);
  AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(ack && err)); // R11
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (ack || err) |=> !(ack || err)); // R11
  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) ack |-> $past(cyc && stb)); // R4
  AST_PUSH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(push_vec)); // R1

  generate
    for (genvar p = 0; p < NP; p++) begin : g_chk
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) !(push_vec[p] && out_full[p])); // R4
      AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid[p] && !src_ready[p] && !push_vec[p]) |=> (src_valid[p] && $stable(src_data[p*DW +: DW]))); // R8
    end
  endgenerate
endmodule

bind wb_port_array wbpa_checker #(.NP(NP), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cyc(wb_cyc_i), .stb(wb_stb_i),
  .ack(wb_ack_o), .err(wb_err_o),
  .src_valid(src_valid_o), .src_ready(src_ready_i), .src_data(src_data_o),
  .push_vec(wr_push), .out_full(out_full)
);

// File: tb/tb_wb_port_array.sv
module tb_wb_port_array;
  logic         clk, rst_n;
  logic         cyc, stb, we;
  logic [4:2]   adr;
  logic [31:0]  wdat, rdat;
  logic         ack, err;
  logic [3:0]   src_valid, src_ready, snk_valid, snk_ready;
  logic [127:0] src_data, snk_data;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  wb_port_array dut (
    .clk(clk), .rst_n(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack), .wb_err_o(err),
    .src_valid_o(src_valid), .src_data_o(src_data), .src_ready_i(src_ready),
    .snk_valid_i(snk_valid), .snk_data_i(snk_data), .snk_ready_o(snk_ready)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [2:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic ak, output logic er, output int n);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = a; wdat = d; n = 0; ak = 0; er = 0; rd = '0;
    while (n < 400) begin
      @(posedge clk); @(negedge clk); n++;
      if (ack || err) begin ak = ack; er = err; rd = rdat; break; end
    end
    cyc = 0; stb = 0; we = 0;
  endtask

  task automatic pop_src(input int p, input logic [31:0] exp, input string req);
    @(negedge clk);
    check(src_valid[p] && src_data[p*32 +: 32] == exp, req, src_data[p*32 +: 32], exp);
    src_ready[p] = 1;
    @(negedge clk);
    src_ready[p] = 0;
  endtask

  task automatic t_reset;
    logic [31:0] r; logic a, e; int n;
    @(negedge clk);
    check(!ack && !err, "R10 ack/err", {30'd0, ack, err}, 0);
    check(src_valid == 4'h0, "R10 src_valid", {28'd0, src_valid}, 0);
    check(snk_ready == 4'hF, "R10 snk_ready", {28'd0, snk_ready}, 32'hF);
    access(0, 3'b100, 0, r, a, e, n);
    check(a && r == 32'h0000_00F0, "R10 R9 status", r, 32'hF0);
    check(n == 1, "R11 ack latency", n, 1);
  endtask

  task automatic t_route;
    logic [31:0] r; logic a, e; int n;
    access(1, 3'd2, 32'hA5A5_0001, r, a, e, n);
    check(a && !e && n == 1, "R11 write ack", n, 1);
    @(negedge clk);
    check(src_valid == 4'b0100, "R1 port route", {28'd0, src_valid}, 32'h4);
    access(1, 3'd2, 32'hA5A5_0002, r, a, e, n);
    repeat (3) @(negedge clk);
    check(src_data[64 +: 32] == 32'hA5A5_0001, "R8 head held", src_data[64 +: 32], 32'hA5A5_0001);
    pop_src(2, 32'hA5A5_0001, "R1 order 1");
    pop_src(2, 32'hA5A5_0002, "R1 order 2");
    check(src_valid == 4'b0000, "R1 drained", {28'd0, src_valid}, 0);
  endtask

  task automatic t_full;
    logic [31:0] r; logic a, e; int n; bit allok = 1;
    for (int i = 0; i < 16; i++) begin
      access(1, 3'd1, 32'h1000 + i, r, a, e, n);
      if (!(a && n == 1)) allok = 0;
    end
    check(allok, "R3 sixteen writes no stall", {31'd0, allok}, 1);
    access(0, 3'b100, 0, r, a, e, n);
    check(r[3:0] == 4'b0010, "R9 full flag", r, 32'h2);
    access(1, 3'd1, 32'hDEAD_BEEF, r, a, e, n);
    check(e && !a, "R4 err on full", {30'd0, a, e}, 1);
    check(n == 256, "R4 wait window", n, 256);
    for (int i = 0; i < 16; i++) pop_src(1, 32'h1000 + i, "R3 drain order");
    @(negedge clk);
    check(!src_valid[1], "R4 nothing pushed", {31'd0, src_valid[1]}, 0);
  endtask

  task automatic t_release;
    logic [31:0] r; logic a, e; int n;
    for (int i = 0; i < 16; i++) access(1, 3'd0, 32'h2000 + i, r, a, e, n);
    fork
      access(1, 3'd0, 32'h2FFF, r, a, e, n);
      begin
        repeat (12) @(negedge clk);
        src_ready[0] = 1;
        @(negedge clk);
        src_ready[0] = 0;
      end
    join
    check(a && !e && n < 256, "R6 late ack", n, 12);
    for (int i = 1; i < 16; i++) pop_src(0, 32'h2000 + i, "R6 drain");
    pop_src(0, 32'h2FFF, "R6 pushed word last");
  endtask

  task automatic t_inbound;
    logic [31:0] r; logic a, e; int n; bit allok = 1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      snk_valid[3] = 1; snk_data[96 +: 32] = 32'h3000 + i;
    end
    @(negedge clk);
    snk_valid[3] = 0;
    check(snk_ready[3] == 0, "R7 ready low at 16", {31'd0, snk_ready[3]}, 0);
    snk_valid[3] = 1; snk_data[96 +: 32] = 32'hBAD0_0000;
    @(negedge clk);
    snk_valid[3] = 0;
    for (int i = 0; i < 16; i++) begin
      access(0, 3'd3, 0, r, a, e, n);
      if (!(a && r == 32'h3000 + i)) allok = 0;
    end
    check(allok, "R2 read order", {31'd0, allok}, 1);
    check(snk_ready[3], "R7 ready back", {31'd0, snk_ready[3]}, 1);
    access(0, 3'b100, 0, r, a, e, n);
    check(r == 32'h0000_00F0, "R7 extra word not taken", r, 32'hF0);
    access(0, 3'd0, 0, r, a, e, n);
    check(e && !a && n == 256, "R5 err on empty", n, 256);
  endtask

  task automatic t_stat_write;
    logic [31:0] r; logic a, e; int n;
    access(1, 3'b100, 32'hFFFF_FFFF, r, a, e, n);
    check(a && !e, "R9 status write ack", {30'd0, a, e}, 2);
    access(0, 3'b100, 0, r, a, e, n);
    check(r == 32'h0000_00F0, "R9 status unchanged", r, 32'hF0);
    @(negedge clk);
    check(src_valid == 4'h0, "R9 no stream effect", {28'd0, src_valid}, 0);
  endtask

  initial begin
    int cyc_cnt = 0;
    while (!finished) begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    cyc = 0; stb = 0; we = 0; adr = '0; wdat = '0;
    src_ready = '0; snk_valid = '0; snk_data = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_route();
    t_full();
    t_release();
    t_inbound();
    t_stat_write();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule